// File: doc/BRIEF.md
# Translation Slot Buffer with Victim Selection and Tag Search

This block keeps a small fully associative translation buffer. It has a fixed number of slots. Each slot pairs a 64-bit tag with a 64-bit translation word. Within each translation word, bit 63 marks the slot as valid and bit 6 marks it as locked against replacement. The block accepts one request at a time, from a single request port with a 2-bit opcode. There are three operations:

- **Automatic fill.** The block chooses the slot to overwrite.
- **Direct write.** The slot number is taken from an address field.
- **Lookup.** The block searches the stored tags for a key and returns the match.

Every write stores the value on the tag-access input, sampled in the cycle the request is accepted. The other half of the slot comes from the request data.

Lookups and automatic fills walk the slots one per cycle, from slot 0 upward. A busy flag is high while a request is in flight. A one-cycle done pulse closes each request, and the lookup result is valid during that pulse. A request offered while busy is high is ignored.

Top module: `xlat_slot_buffer`

## Requirements
- R1: After reset, busy and done are low, and every slot is invalid, so any lookup returns zero.
- R2: An automatic fill (opcode 1) writes into the lowest-numbered slot whose valid bit (bit 63) is clear.
- R3: When every slot is valid, an automatic fill writes into the lowest-numbered slot whose lock bit (bit 6) is clear.
- R4: When every slot is both valid and locked, an automatic fill leaves all slots unchanged.
- R5: A direct write (opcode 2) overwrites the slot selected by address bits [8:3], whether or not that slot is valid or locked; all other address bits are ignored.
- R6: A lookup (opcode 0) returns the tag of the lowest-numbered valid slot whose tag equals the key on the data input, and returns zero when no valid slot matches. Invalid slots never match.
- R7: The tag stored by either write is the tag-access value present in the cycle the request is accepted.
- R8: done is a single-cycle pulse that occurs only while busy is high. A request presented while busy is high is not accepted.
- R9: A direct write raises done in the cycle after acceptance. A lookup that matches at slot k raises done k+2 cycles after acceptance. No request keeps busy high for more than SLOTS+1 cycles.
- R10: Opcode 3 completes with a done pulse and changes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered; taken when busy is low |
| req_op | input | 2 | 0 lookup, 1 automatic fill, 2 direct write, 3 no operation |
| req_addr | input | ADDR_W | Address; bits [8:3] select the slot for a direct write |
| req_data | input | 64 | Translation word for writes, search key for lookups |
| tag_access | input | 64 | Tag stored by writes |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle completion pulse |
| rsp_tag | output | 64 | Lookup result, valid while done is high |

## Verification
The hardest state to reach from the ports is a completely full buffer. In that state victim choice depends only on lock bits, and in the all-locked case a fill must vanish without trace. The stimulus gets there by direct-writing every slot with a chosen lock pattern. It then shows where a fill landed by checking which earlier tag disappears from lookups.

The order of the scan is also proven from timing. A lookup matching at a high slot, with an invalid duplicate tag in a lower slot, must finish in the cycle count that belongs to the valid slot.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int TAG_W     = 64;
    localparam int TTE_W     = 64;
    localparam int VALID_BIT = 63;
    localparam int LOCK_BIT  = 6;

    typedef enum logic [1:0] {
        OP_LOOKUP   = 2'd0,
        OP_AUTOFILL = 2'd1,
        OP_DIRECT   = 2'd2,
        OP_NONE     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [TTE_W-1:0] tte;
    } slot_t;

    typedef struct packed {
        op_e              op;
        logic [TAG_W-1:0] key;
        slot_t            wr;
    } job_t;

    function automatic logic tte_valid(input logic [TTE_W-1:0] t);
        return t[VALID_BIT];
    endfunction

    function automatic logic tte_locked(input logic [TTE_W-1:0] t);
        return t[LOCK_BIT];
    endfunction

endpackage

// File: rtl/xlat_slot_array.sv
module xlat_slot_array
    import xlat_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  slot_t         wdata,
    input  logic [IW-1:0] raddr,
    output slot_t         rdata
);

    slot_t slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (we && (waddr == IW'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/xlat_scan_ctrl.sv
module xlat_scan_ctrl
    import xlat_pkg::*;
#(
    parameter int SLOTS = 64,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  op_e              req_op,
    input  logic [IW-1:0]    req_index,
    input  logic [TTE_W-1:0] req_data,
    input  logic [TAG_W-1:0] req_tag,
    input  slot_t            cur,
    output logic [IW-1:0]    scan_idx,
    output logic             we,
    output logic [IW-1:0]    waddr,
    output slot_t            wdata,
    output logic             busy,
    output logic             done,
    output logic [TAG_W-1:0] rsp_tag
);

    localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

    state_e           st;
    job_t             job;
    logic [IW-1:0]    cnt;
    logic [IW-1:0]    tgt;
    logic [IW-1:0]    free_idx;
    logic             have_free;
    logic             wr_go;
    logic [TAG_W-1:0] rsp;
    logic             at_end;
    logic             cur_hit;

    assign at_end  = (cnt == LAST);
    assign cur_hit = tte_valid(cur.tte) && (cur.tag == job.key);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            job       <= '0;
            cnt       <= '0;
            tgt       <= '0;
            free_idx  <= '0;
            have_free <= 1'b0;
            wr_go     <= 1'b0;
            rsp       <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        job.op     <= req_op;
                        job.key    <= req_data;
                        job.wr.tag <= req_tag;
                        job.wr.tte <= req_data;
                        cnt        <= '0;
                        have_free  <= 1'b0;
                        rsp        <= '0;
                        tgt        <= req_index;
                        wr_go      <= (req_op == OP_DIRECT);
                        if (req_op == OP_LOOKUP || req_op == OP_AUTOFILL) begin
                            st <= ST_SCAN;
                        end else begin
                            st <= ST_COMMIT;
                        end
                    end
                end
                ST_SCAN: begin
                    if (job.op == OP_LOOKUP) begin
                        if (cur_hit) begin
                            rsp <= cur.tag;
                            st  <= ST_COMMIT;
                        end else if (at_end) begin
                            st <= ST_COMMIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        if (!tte_valid(cur.tte)) begin
                            tgt   <= cnt;
                            wr_go <= 1'b1;
                            st    <= ST_COMMIT;
                        end else begin
                            if (!tte_locked(cur.tte) && !have_free) begin
                                have_free <= 1'b1;
                                free_idx  <= cnt;
                            end
                            if (at_end) begin
                                st <= ST_COMMIT;
                                if (have_free) begin
                                    tgt   <= free_idx;
                                    wr_go <= 1'b1;
                                end else if (!tte_locked(cur.tte)) begin
                                    tgt   <= cnt;
                                    wr_go <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_COMMIT: begin
                    st    <= ST_IDLE;
                    wr_go <= 1'b0;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_COMMIT);
    assign we       = done && wr_go;
    assign waddr    = tgt;
    assign wdata    = job.wr;
    assign scan_idx = cnt;
    assign rsp_tag  = rsp;

endmodule

// File: rtl/xlat_slot_buffer.sv
module xlat_slot_buffer
    import xlat_pkg::*;
#(
    parameter int SLOTS   = 64,
    parameter int ADDR_W  = 64,
    parameter int IDX_LSB = 3,
    localparam int IW = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TTE_W-1:0]  req_data,
    input  logic [TAG_W-1:0]  tag_access,
    output logic              busy,
    output logic              done,
    output logic [TAG_W-1:0]  rsp_tag
);

    logic [IW-1:0] req_index;
    logic          unused_addr_bits;
    logic [IW-1:0] scan_idx;
    logic          we;
    logic [IW-1:0] waddr;
    slot_t         wdata;
    slot_t         cur;

    assign req_index        = req_addr[IDX_LSB +: IW];
    assign unused_addr_bits = ^{req_addr[ADDR_W-1:IDX_LSB+IW], req_addr[IDX_LSB-1:0]};

    xlat_slot_array #(.SLOTS(SLOTS)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (scan_idx),
        .rdata (cur)
    );

    xlat_scan_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (op_e'(req_op)),
        .req_index (req_index),
        .req_data  (req_data),
        .req_tag   (tag_access),
        .cur       (cur),
        .scan_idx  (scan_idx),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .busy      (busy),
        .done      (done),
        .rsp_tag   (rsp_tag)
    );

endmodule

// File: rtl/xlat_slot_buffer_chk.sv
module xlat_slot_buffer_chk #(
    parameter int SLOTS = 64
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic [63:0] req_data,
    input logic        busy,
    input logic        done,
    input logic [63:0] rsp_tag
);

    logic [1:0]  last_op;
    logic [63:0] last_key;
    logic [15:0] busy_cnt;
    logic        accept;

    assign accept = req_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_op  <= 2'd3;
            last_key <= '0;
            busy_cnt <= '0;
        end else begin
            if (accept) begin
                last_op  <= req_op;
                last_key <= req_data;
            end
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done)); // R1

    AST_LOOKUP_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && last_op == 2'd0) |-> (rsp_tag == 64'd0 || rsp_tag == last_key)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R8

    AST_DIRECT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op == 2'd2) |=> done); // R9

    AST_NOOP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (accept && req_op == 2'd3) |=> done); // R10

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt <= 16'(SLOTS))); // R9

endmodule

bind xlat_slot_buffer xlat_slot_buffer_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_data  (req_data),
    .busy      (busy),
    .done      (done),
    .rsp_tag   (rsp_tag)
);

// File: tb/sim_xlat_slot_buffer.sv
module sim_xlat_slot_buffer;

    localparam logic [63:0] V = 64'h8000_0000_0000_0000;
    localparam logic [63:0] L = 64'h0000_0000_0000_0040;

    typedef struct packed {
        logic [1:0]  op;
        logic [63:0] addr;
        logic [63:0] data;
        logic [63:0] tag;
        logic        chk;
        logic [63:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 64'd0, V, 64'hA0, 1'b0, 64'd0, 8'd2},                        // R2 fill -> slot 0
        '{2'd0, 64'd0, 64'hA0, 64'd0, 1'b1, 64'hA0, 8'd2},                   // R2
        '{2'd1, 64'd0, V, 64'hB0, 1'b0, 64'd0, 8'd2},                        // R2 fill -> slot 1
        '{2'd0, 64'd0, 64'hB0, 64'd0, 1'b1, 64'hB0, 8'd2},                   // R2
        '{2'd2, 64'hFFFF_0000_0000_0005, 64'd0, 64'hC0, 1'b0, 64'd0, 8'd5},  // R5 slot 0 invalid
        '{2'd0, 64'd0, 64'hA0, 64'd0, 1'b1, 64'd0, 8'd5},                    // R5 A0 gone
        '{2'd0, 64'd0, 64'hC0, 64'd0, 1'b1, 64'd0, 8'd6},                    // R6 invalid no match
        '{2'd1, 64'd0, V, 64'hD0, 1'b0, 64'd0, 8'd2},                        // R2 lowest invalid = 0
        '{2'd2, 64'd0, 64'd0, 64'hE0, 1'b0, 64'd0, 8'd2},                    // R2 clear slot 0
        '{2'd0, 64'd0, 64'hD0, 64'd0, 1'b1, 64'd0, 8'd2},                    // R2 D0 was in slot 0
        '{2'd0, 64'd0, 64'hB0, 64'd0, 1'b1, 64'hB0, 8'd6},                   // R6
        '{2'd3, 64'd0, V, 64'hF0, 1'b0, 64'd0, 8'd10},                       // R10 no-op
        '{2'd0, 64'd0, 64'hF0, 64'd0, 1'b1, 64'd0, 8'd10},                   // R10
        '{2'd0, 64'd0, 64'hB0, 64'd0, 1'b1, 64'hB0, 8'd10}                   // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [63:0] req_addr = '0;
    logic [63:0] req_data = '0;
    logic [63:0] tag_access = '0;
    logic        busy;
    logic        done;
    logic [63:0] rsp_tag;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    xlat_slot_buffer u0 (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .tag_access (tag_access),
        .busy       (busy),
        .done       (done),
        .rsp_tag    (rsp_tag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [63:0] addr,
                          input logic [63:0] data, input logic [63:0] tag,
                          output logic [63:0] rsp, output int cyc);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_addr   = addr;
        req_data   = data;
        tag_access = tag;
        @(negedge clk);
        req_valid  = 1'b0;
        tag_access = ~tag;   // R7: changed after acceptance
        req_data   = ~data;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        rsp = rsp_tag;
    endtask

    task automatic lookup(input string req, input logic [63:0] key, input logic [63:0] exp);
        logic [63:0] r;
        int c;
        run_op(2'd0, 64'd0, key, 64'd0, r, c);
        check(req, r, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int c;

        do_reset();
        @(negedge clk);
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 done", {63'd0, done}, 64'd0);
        lookup("R1 empty lookup", 64'd0, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].tag, r, c);
            if (VECS[i].chk) begin
                check($sformatf("R%0d table row %0d", VECS[i].req, i), r, VECS[i].exp);
            end
        end

        // R1: reset forgets all contents
        do_reset();
        lookup("R1 after reset", 64'hB0, 64'd0);

        // Fill every slot; only 20 and 40 unlocked
        for (int i = 0; i < 64; i++) begin
            run_op(2'd2, 64'(i) << 3, V | ((i == 20 || i == 40) ? 64'd0 : L),
                   64'h1000 + 64'(i), r, c);
        end
        run_op(2'd1, 64'd0, V | L, 64'h5A5A, r, c);
        check("R9 full scan cycles", 64'(c), 64'd65);
        lookup("R3 slot20 replaced", 64'h1014, 64'd0);
        lookup("R3 new tag present", 64'h5A5A, 64'h5A5A);
        lookup("R3 slot40 kept", 64'h1028, 64'h1028);

        // R4: lock slot 40 too; fill must vanish
        run_op(2'd2, 64'd40 << 3, V | L, 64'h1028, r, c);
        check("R9 direct latency", 64'(c), 64'd1);
        run_op(2'd1, 64'd0, V, 64'h7777, r, c);
        lookup("R4 dropped fill", 64'h7777, 64'd0);
        lookup("R4 slot20 kept", 64'h5A5A, 64'h5A5A);
        lookup("R4 slot40 kept", 64'h1028, 64'h1028);
        lookup("R4 slot0 kept", 64'h1000, 64'h1000);

        // R5: direct write overrides a locked valid slot
        run_op(2'd2, 64'd20 << 3, V | L, 64'h3131, r, c);
        lookup("R5 overwrite locked", 64'h3131, 64'h3131);
        lookup("R5 old tag gone", 64'h5A5A, 64'd0);

        // R6: invalid duplicate at 3, valid at 50 and 60
        run_op(2'd2, 64'd3 << 3, 64'd0, 64'h4D4D, r, c);
        run_op(2'd2, 64'd50 << 3, V, 64'h4D4D, r, c);
        run_op(2'd2, 64'd60 << 3, V, 64'h4D4D, r, c);
        run_op(2'd0, 64'd0, 64'h4D4D, 64'd0, r, c);
        check("R6 match value", r, 64'h4D4D);
        check("R9 R6 match at slot 50 cycles", 64'(c), 64'd52);

        // R7: tag sampled at acceptance
        run_op(2'd2, 64'd7 << 3, V, 64'h7070, r, c);
        lookup("R7 accepted tag", 64'h7070, 64'h7070);
        lookup("R7 later tag", ~64'h7070, 64'd0);

        // R8: request during busy is ignored; done is one cycle
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'd0;
        req_data  = 64'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        req_valid  = 1'b1;
        req_op     = 2'd2;
        req_addr   = 64'd9 << 3;
        req_data   = V;
        tag_access = 64'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        c = 0;
        while (!done && c < 1000) begin
            @(negedge clk);
            c++;
        end
        check("R8 miss result", rsp_tag, 64'd0);
        @(negedge clk);
        check("R8 done single cycle", {63'd0, done}, 64'd0);
        lookup("R8 busy request ignored", 64'h9999, 64'd0);
        lookup("R8 slot9 kept", 64'h1009, 64'h1009);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule